// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block carries words from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`. The two clocks need no phase or frequency relation. The word at the head of the queue is held in a dedicated output register. That register is filled without any request as soon as a word becomes visible on the read side. The consumer therefore sees valid data on `rd_data` whenever `out_ready` is high, and `rd_en` only discards the head so that the next word can move up.

Each side has two status outputs, and both are registered in that side's own clock domain. On the read side these are `out_ready` and the active-low `almost_empty_n`. On the write side they are `in_ready` and the active-low `almost_full_n`. Each domain sees the other domain's pointer as a Gray-coded value passed through a chain of synchronizer flops. The memory depth and both threshold offsets are parameters.

Once a word has moved into the output register, its memory slot is released. The queue can therefore hold one word more than the memory depth.

Top module: `dcfifo_ft`

## Requirements
- R1: While `rst_n` is low, `out_ready`=0, `almost_empty_n`=0, `in_ready`=0 and `almost_full_n`=1. After `rst_n` is released with the queue empty, `in_ready` rises to 1 within a few write clocks.
- R2: When a word is written into an empty queue, it appears on `rd_data` with `out_ready`=1 and no `rd_en` asserted. With no words queued, `out_ready` is 0.
- R3: Words leave in the order they were written. A rising `rd_clk` edge with `rd_en`=1 and `out_ready`=1 replaces the head with the next word. With `rd_en`=0, `rd_data` and `out_ready` hold.
- R4: Let L be the number of words written and not yet discarded, counting the word in the output register. When settled, `almost_empty_n` is 0 for L <= AE_OFFSET and 1 for L >= AE_OFFSET+1.
- R5: Let M be the memory occupancy, which is L-1 while the output register holds a word and 0 when L=0. When settled, `almost_full_n` is 1 for M < DEPTH-AF_OFFSET and 0 for M >= DEPTH-AF_OFFSET.
- R6: `in_ready` is 1 for M < DEPTH and 0 for M = DEPTH. The queue therefore accepts DEPTH+1 words before it refuses more.
- R7: A write presented while `in_ready` is 0 is dropped. It changes neither the queue contents, nor the order in which words come out, nor the flags.
- R8: An `rd_en` presented while `out_ready` is 0 is ignored. No later word is lost or skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en | input | 1 | Write request, sampled on rising `wr_clk` |
| wr_data | input | WIDTH | Word to store |
| in_ready | output | 1 | High when a write will be accepted |
| almost_full_n | output | 1 | Low when memory occupancy reaches DEPTH-AF_OFFSET |
| rd_en | input | 1 | Discard the head word, sampled on rising `rd_clk` |
| rd_data | output | WIDTH | Head word held in the output register |
| out_ready | output | 1 | High when `rd_data` holds a valid word |
| almost_empty_n | output | 1 | Low when at most AE_OFFSET words are queued |

## Verification
The hardest state to reach is a completely full queue, where the memory holds DEPTH words and one more sits in the output register. In that state `in_ready` must be low while the memory is full and the output register is occupied. The stimulus writes DEPTH+1 words with reads held off, and it checks each flag just before and just after every threshold: AE_OFFSET, DEPTH-AF_OFFSET and DEPTH+1 words. It then presents a write that must be refused and drains the whole queue, comparing every word against the expected order.

// File: rtl/dcfifo_ft_pkg.sv
package dcfifo_ft_pkg;

   localparam int PTR_W_MAX = 16;

   typedef logic [PTR_W_MAX-1:0] ptr_word_t;

   // Zero-extended operands keep both conversions valid for any narrower width.
   function automatic ptr_word_t bin2gray(ptr_word_t b);
      return b ^ (b >> 1);
   endfunction

   function automatic ptr_word_t gray2bin(ptr_word_t g);
      ptr_word_t b;
      b = g;
      for (int i = 1; i < PTR_W_MAX; i++) begin
         b = b ^ (g >> i);
      end
      return b;
   endfunction

endpackage

// File: rtl/dcfifo_ft_ptrx.sv
// Moves a binary pointer into another clock domain as registered Gray code.
module dcfifo_ft_ptrx
   import dcfifo_ft_pkg::*;
#(
   parameter int PW     = 10,
   parameter int STAGES = 2
) (
   input  logic          src_clk,
   input  logic          dst_clk,
   input  logic          rst_n,
   input  logic [PW-1:0] src_bin,
   output logic [PW-1:0] dst_bin
);

   if (PW > PTR_W_MAX) begin : g_bad_width
      initial $fatal(1, "dcfifo_ft_ptrx: PW exceeds PTR_W_MAX");
   end
   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "dcfifo_ft_ptrx: at least two sync stages required");
   end

   logic [PW-1:0] src_gray;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) src_gray <= '0;
      else        src_gray <= PW'(bin2gray(ptr_word_t'(src_bin)));
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [PW-1:0] q;
      if (s == 0) begin : g_head
         always_ff @(posedge dst_clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= src_gray;
         end
      end else begin : g_tail
         always_ff @(posedge dst_clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_stage[s-1].q;
         end
      end
   end

   assign dst_bin = PW'(gray2bin(ptr_word_t'(g_stage[STAGES-1].q)));

endmodule

// File: rtl/dcfifo_ft_ram.sv
// Storage array: synchronous write on the write clock, combinational read.
module dcfifo_ft_ram #(
   parameter int WIDTH = 36,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             wr_clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/dcfifo_ft_wside.sv
// Write-domain pointer and the flags registered on the write clock.
module dcfifo_ft_wside #(
   parameter int DEPTH     = 512,
   parameter int AF_OFFSET = 8,
   parameter int PW        = 10
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] rptr_sync,
   output logic [PW-1:0] wptr,
   output logic          push,
   output logic [PW-1:0] used,
   output logic          in_ready,
   output logic          almost_full_n
);

   localparam logic [PW-1:0] FULL_AT = PW'(DEPTH);
   localparam logic [PW-1:0] AF_AT   = PW'(DEPTH - AF_OFFSET);

   logic [PW-1:0] wptr_nxt;
   logic [PW-1:0] used_nxt;

   assign push     = wr_en && in_ready;
   assign wptr_nxt = wptr + PW'(push);
   assign used     = wptr - rptr_sync;
   assign used_nxt = wptr_nxt - rptr_sync;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr          <= '0;
         in_ready      <= 1'b0;
         almost_full_n <= 1'b1;
      end else begin
         wptr          <= wptr_nxt;
         in_ready      <= (used_nxt < FULL_AT);
         almost_full_n <= (used_nxt < AF_AT);
      end
   end

endmodule

// File: rtl/dcfifo_ft_rside.sv
// Read-domain pointer, self-filling output register and read-clock flags.
module dcfifo_ft_rside #(
   parameter int WIDTH     = 36,
   parameter int AE_OFFSET = 8,
   parameter int PW        = 10
) (
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [PW-1:0]    wptr_sync,
   input  logic [WIDTH-1:0] ram_q,
   output logic [PW-1:0]    rptr,
   output logic [WIDTH-1:0] rd_data,
   output logic             out_ready,
   output logic             almost_empty_n
);

   localparam logic [PW-1:0] AE_AT = PW'(AE_OFFSET);

   logic          has_word;
   logic          load;
   logic          or_nxt;
   logic [PW-1:0] rptr_nxt;
   logic [PW-1:0] level_nxt;

   assign has_word  = (wptr_sync != rptr);
   assign load      = has_word && (!out_ready || rd_en);
   assign rptr_nxt  = rptr + PW'(load);
   assign or_nxt    = load ? 1'b1 : (rd_en ? 1'b0 : out_ready);
   assign level_nxt = (wptr_sync - rptr_nxt) + PW'(or_nxt);

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr           <= '0;
         rd_data        <= '0;
         out_ready      <= 1'b0;
         almost_empty_n <= 1'b0;
      end else begin
         rptr           <= rptr_nxt;
         out_ready      <= or_nxt;
         almost_empty_n <= (level_nxt > AE_AT);
         if (load) rd_data <= ram_q;
      end
   end

endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
   parameter int WIDTH       = 36,
   parameter int DEPTH       = 512,
   parameter int AE_OFFSET   = 8,
   parameter int AF_OFFSET   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic             in_ready,
   output logic             almost_full_n,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             out_ready,
   output logic             almost_empty_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
      initial $fatal(1, "dcfifo_ft: DEPTH must be a power of two >= 4");
   end
   if (AE_OFFSET < 1 || AF_OFFSET < 1 || AE_OFFSET + AF_OFFSET >= DEPTH) begin : g_bad_offsets
      initial $fatal(1, "dcfifo_ft: offsets must be >= 1 and sum below DEPTH");
   end
   if (WIDTH < 1) begin : g_bad_width
      initial $fatal(1, "dcfifo_ft: WIDTH must be positive");
   end

   logic [PW-1:0]    wptr_w;
   logic [PW-1:0]    used_w;
   logic [PW-1:0]    rptr_in_w;
   logic [PW-1:0]    rptr_r;
   logic [PW-1:0]    wptr_in_r;
   logic             push_w;
   logic [WIDTH-1:0] ram_q;

   dcfifo_ft_wside #(
      .DEPTH(DEPTH), .AF_OFFSET(AF_OFFSET), .PW(PW)
   ) u_wside (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rptr_sync(rptr_in_w),
      .wptr(wptr_w), .push(push_w), .used(used_w),
      .in_ready(in_ready), .almost_full_n(almost_full_n)
   );

   dcfifo_ft_ptrx #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .src_clk(wr_clk), .dst_clk(rd_clk), .rst_n(rst_n),
      .src_bin(wptr_w), .dst_bin(wptr_in_r)
   );

   dcfifo_ft_ptrx #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .src_clk(rd_clk), .dst_clk(wr_clk), .rst_n(rst_n),
      .src_bin(rptr_r), .dst_bin(rptr_in_w)
   );

   dcfifo_ft_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
      .wr_clk(wr_clk), .we(push_w), .waddr(wptr_w[AW-1:0]), .wdata(wr_data),
      .raddr(rptr_r[AW-1:0]), .rdata(ram_q)
   );

   dcfifo_ft_rside #(
      .WIDTH(WIDTH), .AE_OFFSET(AE_OFFSET), .PW(PW)
   ) u_rside (
      .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .wptr_sync(wptr_in_r),
      .ram_q(ram_q), .rptr(rptr_r), .rd_data(rd_data),
      .out_ready(out_ready), .almost_empty_n(almost_empty_n)
   );

endmodule

// File: rtl/dcfifo_ft_chk.sv
module dcfifo_ft_chk #(
   parameter int WIDTH = 36,
   parameter int DEPTH = 512,
   parameter int PW    = 10
) (
   input logic             wr_clk,
   input logic             rd_clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             in_ready,
   input logic             almost_full_n,
   input logic             rd_en,
   input logic             out_ready,
   input logic             almost_empty_n,
   input logic [WIDTH-1:0] rd_data,
   input logic [PW-1:0]    wptr,
   input logic [PW-1:0]    rptr,
   input logic [PW-1:0]    wr_used
);

   // R7: a refused write leaves the write pointer where it was
   a_r7_refused_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en && !in_ready) |=> (wptr == $past(wptr)));

   // R6: memory occupancy seen on the write side never exceeds the depth
   a_r6_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wr_used <= PW'(DEPTH));

   // R5: once input-ready drops, almost-full is already asserted
   a_r5_full_implies_af: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $fell(in_ready) |-> !almost_full_n);

   // R4: leaving almost-empty requires a valid head word
   a_r4_ae_needs_head: assert property (@(posedge rd_clk) disable iff (!rst_n)
      almost_empty_n |-> out_ready);

   // R3: without a read, the head word and its valid flag hold
   a_r3_head_holds: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (out_ready && !rd_en) |=> (out_ready && $stable(rd_data)));

   // R2: the edge that raises output-ready also consumes a memory slot
   a_r2_fill_on_rise: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $rose(out_ready) |-> (rptr != $past(rptr)));

endmodule

bind dcfifo_ft dcfifo_ft_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) chk_i (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
   .in_ready(in_ready), .almost_full_n(almost_full_n), .rd_en(rd_en),
   .out_ready(out_ready), .almost_empty_n(almost_empty_n), .rd_data(rd_data),
   .wptr(wptr_w), .rptr(rptr_r), .wr_used(used_w)
);

// File: tb/dcfifo_ft_tb_top.sv
module dcfifo_ft_tb_top;

   localparam int WCLK_PERIOD = 10;
   localparam int RCLK_PERIOD = 14;
   localparam int WIDTH = 36;
   localparam int DEPTH = 512;
   localparam int XOFF  = 8;
   localparam int YOFF  = 8;

   logic wr_clk = 1'b0;
   logic rd_clk = 1'b0;
   logic rst_n  = 1'b0;
   logic wr_en  = 1'b0;
   logic rd_en  = 1'b0;
   logic [WIDTH-1:0] wr_data = '0;
   logic [WIDTH-1:0] rd_data;
   logic in_ready, almost_full_n, out_ready, almost_empty_n;

   int checks   = 0;
   int failures = 0;
   bit finished = 0;
   logic [WIDTH-1:0] model[$];

   always #(WCLK_PERIOD/2) wr_clk = ~wr_clk;
   always #(RCLK_PERIOD/2) rd_clk = ~rd_clk;

   dcfifo_ft #(
      .WIDTH(WIDTH), .DEPTH(DEPTH), .AE_OFFSET(XOFF), .AF_OFFSET(YOFF), .SYNC_STAGES(2)
   ) dut_i (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_data(wr_data), .in_ready(in_ready), .almost_full_n(almost_full_n),
      .rd_en(rd_en), .rd_data(rd_data), .out_ready(out_ready),
      .almost_empty_n(almost_empty_n)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [WIDTH-1:0] v, input bit expect_take);
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge wr_clk);
      wr_en   = 1'b0;
      if (expect_take) model.push_back(v);
   endtask

   task automatic pop();
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (12) @(posedge rd_clk);
      @(negedge rd_clk);
   endtask

   // Compares all four flags and the head word against the expected level.
   task automatic check_level(input string tag);
      int k;
      int m;
      k = model.size();
      m = (k > 0) ? k - 1 : 0;
      check({tag, " R2 out_ready"}, 64'(out_ready), 64'(k >= 1));
      check({tag, " R4 almost_empty_n"}, 64'(almost_empty_n), 64'(k >= XOFF + 1));
      if (k >= 1) check({tag, " R3 head word"}, 64'(rd_data), 64'(model[0]));
      @(negedge wr_clk);
      check({tag, " R5 almost_full_n"}, 64'(almost_full_n), 64'(m < DEPTH - YOFF));
      check({tag, " R6 in_ready"}, 64'(in_ready), 64'(m < DEPTH));
   endtask

   task automatic t_reset();
      #(WCLK_PERIOD * 2);
      check("R1 reset out_ready", 64'(out_ready), 64'd0);
      check("R1 reset almost_empty_n", 64'(almost_empty_n), 64'd0);
      check("R1 reset in_ready", 64'(in_ready), 64'd0);
      check("R1 reset almost_full_n", 64'(almost_full_n), 64'd1);
      #(WCLK_PERIOD + 3);
      rst_n = 1'b1;
      settle();
      @(negedge wr_clk);
      check("R1 in_ready after release", 64'(in_ready), 64'd1);
      check_level("R1 empty");
   endtask

   task automatic t_fallthrough();
      push(36'h1_2345_6789, 1'b1);
      settle();
      check("R2 head without rd_en", 64'(rd_data), 64'h1_2345_6789);
      check_level("R2 one word");
      pop();
      void'(model.pop_front());
      settle();
      check("R2 empty after read", 64'(out_ready), 64'd0);
   endtask

   task automatic t_empty_read();
      repeat (3) pop();
      settle();
      check("R8 still empty", 64'(out_ready), 64'd0);
      push(36'hA_BCDE_F012, 1'b1);
      settle();
      check("R8 word not skipped", 64'(rd_data), 64'hA_BCDE_F012);
      check_level("R8 one word");
      pop();
      void'(model.pop_front());
      settle();
   endtask

   task automatic t_order();
      for (int i = 0; i < 6; i++) push(36'(36'h5_0000_0000 + 36'(i * 7)), 1'b1);
      settle();
      repeat (3) @(negedge rd_clk);
      check("R3 hold without rd_en", 64'(rd_data), 64'(model[0]));
      check("R3 valid held", 64'(out_ready), 64'd1);
      for (int i = 0; i < 6; i++) begin
         @(negedge rd_clk);
         check("R3 order", 64'(rd_data), 64'(model[0]));
         pop();
         void'(model.pop_front());
      end
      settle();
      check("R3 empty after order run", 64'(out_ready), 64'd0);
   endtask

   task automatic t_levels();
      int bad;
      bad = 0;
      while (model.size() < XOFF) push(36'(model.size() + 100), 1'b1);
      settle();
      check_level("R4 at X");
      push(36'(model.size() + 100), 1'b1);
      settle();
      check_level("R4 at X+1");
      while (model.size() < DEPTH - YOFF) push(36'(model.size() + 100), 1'b1);
      settle();
      check_level("R5 below threshold");
      push(36'(model.size() + 100), 1'b1);
      settle();
      check_level("R5 at threshold");
      while (model.size() < DEPTH) push(36'(model.size() + 100), 1'b1);
      settle();
      check_level("R6 depth words");
      push(36'(model.size() + 100), 1'b1);
      settle();
      check_level("R6 depth plus one");
      push(36'hD_EAD0_BEEF, 1'b0);
      settle();
      check_level("R7 after refused write");
      while (model.size() > 0) begin
         @(negedge rd_clk);
         if (rd_data !== model[0] || out_ready !== 1'b1) bad++;
         pop();
         void'(model.pop_front());
      end
      check("R7 drain mismatches", 64'(bad), 64'd0);
      settle();
      check_level("R7 drained");
   endtask

   initial begin
      t_reset();
      t_fallthrough();
      t_empty_read();
      t_order();
      t_levels();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(WCLK_PERIOD * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule